// File: doc/BRIEF.md
# Dual-Mode Serial Clock Generator

This block derives the serial clock of a synchronous serial port from a faster module clock. Two divide laws are available, picked by one mode bit. The linear law divides the module clock by 2*(n+1). The power-of-two law divides it by 2^n. A shift engine next to the block uses two one-cycle strobes to find each serial-clock edge. One strobe marks a rising edge and the other marks a falling edge.

The module clock is meant to run at twice the fastest serial rate a device allows, so linear mode with a zero field gives that fastest rate. In power-of-two mode a zero field passes the module clock straight through a glitch-free gate. Software may rewrite the mode bit or either divider field while the clock runs. The block copies these settings only at the rising edge that ends a full low phase, so the serial clock never produces a short pulse. When the enable is low, the serial clock idles low.

Top module: `sclk_gen`

## Requirements
- R1: In linear mode, with linear field n, a serial-clock period lasts 2*(n+1) module-clock cycles, with n+1 cycles high and n+1 cycles low.
- R2: In power-of-two mode, with power field n >= 1, a period lasts 2^n module-clock cycles, half of them high and half low.
- R3: In power-of-two mode with power field 0, the serial clock follows the module clock (high while it is high, low while it is low), and both strobes are held high.
- R4: A mode bit of 1 selects the linear law and a mode bit of 0 selects the power-of-two law. The field of the law that is not selected has no effect on the output.
- R5: In linear mode with field 0, the serial clock runs at half the module-clock rate (period 2).
- R6: Changes to the mode bit or the divider fields take effect only at the next rising serial-clock edge. The period in progress finishes with the old settings, and the new high phase uses the new settings.
- R7: While enable is low, the serial clock and both strobes are low, and changes to the settings produce no output. When enable rises, the first rising edge comes on the (n+1)-th enabled module-clock edge in linear mode.
- R8: In divider modes, the rise strobe is high for exactly the first cycle of each high phase, and the fall strobe is high for exactly the first cycle of each low phase. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the serial clock; low holds it idle low |
| modeLin | input | 1 | 1 = linear law, 0 = power-of-two law |
| linDiv | input | LIN_W | Linear divider field n |
| powDiv | input | POW_W | Power-of-two exponent n |
| sclk | output | 1 | Serial clock |
| riseStb | output | 1 | One-cycle strobe on a serial-clock rising edge |
| fallStb | output | 1 | One-cycle strobe on a serial-clock falling edge |

## Verification
The properties assume that enable and the settings change only between module-clock edges, and that the serial clock is observed through its registered level. The gated pass-through phase in R3 is checked only by sampling the output pin. The bench drives every input at the falling module-clock edge and changes settings while the clock runs only just after a rise strobe. Before it enters or leaves pass-through mode it drops enable, so each change crosses a single period boundary that is known in advance.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  typedef enum logic {
    MODE_POW = 1'b0,
    MODE_LIN = 1'b1
  } scg_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic stopDiv;  // hold the divider counter and level at zero
    logic bypass;   // pass-through of the module clock is active
  } scg_ctl_t;

endpackage

// File: rtl/sclk_gen_ctrl.sv
module sclk_gen_ctrl
  import sclk_gen_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeLin,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [POW_W-1:0] powDiv,
  input  logic             termHit,
  input  logic             sclkHigh,
  output scg_ctl_t         ctl,
  output logic [CNT_W-1:0] halfM1
);

  scg_mode_e        actMode, nxtMode;
  logic [LIN_W-1:0] actLinDiv, nxtLinDiv;
  logic [POW_W-1:0] actPowDiv, nxtPowDiv;
  logic             bypRun;
  logic             actBypass, nxtBypass, boundary, loadNow;

  assign actBypass = (actMode == MODE_POW) && (actPowDiv == '0);
  // end of a full low phase: the counter is about to raise the clock
  assign boundary  = enable && !actBypass && termHit && !sclkHigh;
  assign loadNow   = !enable || boundary || actBypass;

  always_comb begin
    if (loadNow) begin
      nxtMode   = modeLin ? MODE_LIN : MODE_POW;
      nxtLinDiv = linDiv;
      nxtPowDiv = powDiv;
    end else begin
      nxtMode   = actMode;
      nxtLinDiv = actLinDiv;
      nxtPowDiv = actPowDiv;
    end
  end

  assign nxtBypass = (nxtMode == MODE_POW) && (nxtPowDiv == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMode   <= MODE_LIN;
      actLinDiv <= '0;
      actPowDiv <= '0;
      bypRun    <= 1'b0;
    end else begin
      actMode   <= nxtMode;
      actLinDiv <= nxtLinDiv;
      actPowDiv <= nxtPowDiv;
      bypRun    <= enable && nxtBypass;
    end
  end

  // half period minus one for the active law
  always_comb begin
    if (actMode == MODE_LIN) begin
      halfM1 = CNT_W'(actLinDiv);
    end else if (actPowDiv == '0) begin
      halfM1 = '0;
    end else begin
      halfM1 = (CNT_W'(1) << (actPowDiv - POW_W'(1))) - CNT_W'(1);
    end
  end

  assign ctl.stopDiv = !enable || nxtBypass;
  assign ctl.bypass  = bypRun;

endmodule

// File: rtl/sclk_gen_dp.sv
module sclk_gen_dp
  import sclk_gen_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  scg_ctl_t         ctl,
  input  logic [CNT_W-1:0] halfM1,
  output logic             termHit,
  output logic             sclkReg,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb
);

  logic [CNT_W-1:0] cnt;
  logic             riseQ, fallQ, gateQ;

  assign termHit = (cnt == halfM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      sclkReg <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
    end else if (ctl.stopDiv) begin
      cnt     <= '0;
      sclkReg <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
    end else if (termHit) begin
      cnt     <= '0;
      sclkReg <= !sclkReg;
      riseQ   <= !sclkReg;
      fallQ   <= sclkReg;
    end else begin
      cnt     <= cnt + CNT_W'(1);
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
    end
  end

  // gate enable changes only while the module clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= ctl.bypass;
  end

  assign sclk    = sclkReg | (clk & gateQ);
  assign riseStb = riseQ | ctl.bypass;
  assign fallStb = fallQ | ctl.bypass;

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeLin,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [POW_W-1:0] powDiv,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb
);

  localparam int POW_HALF_W = (1 << POW_W) - 2;
  localparam int CNT_RAW    = (LIN_W > POW_HALF_W) ? LIN_W : POW_HALF_W;
  localparam int CNT_W      = (CNT_RAW < 1) ? 1 : CNT_RAW;

  scg_ctl_t         ctl;
  logic [CNT_W-1:0] halfM1;
  logic             termHit, sclkReg;

  sclk_gen_ctrl #(.LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeLin(modeLin),
    .linDiv(linDiv), .powDiv(powDiv), .termHit(termHit),
    .sclkHigh(sclkReg), .ctl(ctl), .halfM1(halfM1)
  );

  sclk_gen_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .halfM1(halfM1),
    .termHit(termHit), .sclkReg(sclkReg), .sclk(sclk),
    .riseStb(riseStb), .fallStb(fallStb)
  );

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             sclkQ,
  input logic             bypass,
  input logic             riseStb,
  input logic             fallStb,
  input logic [LIN_W-1:0] actLinDiv,
  input logic [POW_W-1:0] actPowDiv,
  input logic             actMode
);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclkQ && !riseStb && !fallStb));

  p_rise_mark_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkQ) |-> riseStb);

  p_fall_mark_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclkQ) && $past(enable)) |-> fallStb);

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bypass |-> !(riseStb && fallStb));

  p_bypass_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> !sclkQ);

  p_cfg_at_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((!$stable(actLinDiv) || !$stable(actPowDiv) || !$stable(actMode))
      && $past(enable)) |-> riseStb);

endmodule

bind sclk_gen sclk_gen_chk #(.LIN_W(LIN_W), .POW_W(POW_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .sclkQ(uDp.sclkReg),
  .bypass(uDp.ctl.bypass), .riseStb(riseStb), .fallStb(fallStb),
  .actLinDiv(uCtrl.actLinDiv), .actPowDiv(uCtrl.actPowDiv),
  .actMode(uCtrl.actMode)
);

// File: tb/test_sclk_gen.sv
module test_sclk_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       modeLin = 1'b1;
  logic [7:0] linDiv = '0;
  logic [3:0] powDiv = '0;
  logic       sclk, riseStb, fallStb;
  int         total = 0;
  int         bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_gen i_sclk_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .modeLin(modeLin),
    .linDiv(linDiv), .powDiv(powDiv), .sclk(sclk),
    .riseStb(riseStb), .fallStb(fallStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // step to the sampling point just after the next falling edge
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic waitRise();
    for (int i = 0; i < 100000; i++) begin
      step();
      if (riseStb) return;
    end
  endtask

  // called with the current sample on a rise; measures one period
  task automatic measure(input int expP, input string req);
    int cyc = 0, hi = 0, fl = 0, both = 0;
    for (int i = 0; i < 70000; i++) begin
      step();
      cyc++;
      if (riseStb && fallStb) both++;
      if (riseStb) break;
      if (sclk) hi++;
      if (fallStb) fl++;
    end
    hi++; // the high sample carrying the starting rise
    check(cyc == expP, {req, " period"}, cyc, expP);
    check(hi == expP/2, {req, " high cycles"}, hi, expP/2);
    check(fl == 1 && both == 0, {req, " fall strobes R8"}, fl, 1);
  endtask

  task automatic setup(input bit m, input int l, input int p);
    step();
    enable = 1'b0;
    step();
    modeLin = m; linDiv = 8'(l); powDiv = 4'(p);
    step();
    enable = 1'b1;
  endtask

  task automatic t_reset();
    check(sclk == 0 && riseStb == 0 && fallStb == 0, "R7 reset idle", sclk, 0);
  endtask

  task automatic t_start_r7();
    int n = 0;
    setup(1'b1, 2, 0);
    for (int i = 0; i < 10; i++) begin
      step(); n++;
      if (riseStb) break;
    end
    check(n == 3, "R7 first rise edge", n, 3);
  endtask

  task automatic t_linear_r1();
    setup(1'b1, 3, 5); waitRise(); measure(8, "R1 lin n=3");
    setup(1'b1, 6, 0); waitRise(); measure(14, "R1 lin n=6");
  endtask

  task automatic t_max_r5();
    setup(1'b1, 0, 2); waitRise(); measure(2, "R5 lin n=0");
  endtask

  task automatic t_pow_r2();
    setup(1'b0, 9, 1); waitRise(); measure(2, "R2 pow n=1");
    setup(1'b0, 0, 3); waitRise(); measure(8, "R2 pow n=3");
    setup(1'b0, 1, 5); waitRise(); measure(32, "R2 pow n=5");
  endtask

  task automatic t_mode_r4();
    setup(1'b1, 2, 2); waitRise(); measure(6, "R4 mode lin");
    modeLin = 1'b0;
    measure(6, "R4 old law finishes");
    measure(4, "R4 mode pow");
  endtask

  task automatic t_change_r6();
    setup(1'b1, 3, 0); waitRise();
    linDiv = 8'd1;
    measure(8, "R6 period in progress");
    measure(4, "R6 new setting");
  endtask

  task automatic t_bypass_r3();
    int okHi = 0, okLo = 0, okStb = 0;
    setup(1'b0, 4, 0);
    for (int i = 0; i < 4; i++) step();
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      if (sclk) okHi++;
      @(negedge clk); #2;
      if (!sclk) okLo++;
      if (riseStb && fallStb) okStb++;
    end
    check(okHi == 6, "R3 high with module clock", okHi, 6);
    check(okLo == 6, "R3 low with module clock", okLo, 6);
    check(okStb == 6, "R3 strobes held", okStb, 6);
  endtask

  task automatic t_disable_r7();
    int seen = 0;
    setup(1'b1, 1, 0); waitRise();
    enable = 1'b0;
    step();
    for (int i = 0; i < 12; i++) begin
      if (i == 4) begin linDiv = 8'd0; modeLin = 1'b0; end
      if (sclk || riseStb || fallStb) seen++;
      step();
    end
    check(seen == 0, "R7 idle while disabled", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rstN = 1'b1;
    step();
    t_reset();
    t_start_r7();
    t_linear_r1();
    t_max_r5();
    t_pow_r2();
    t_mode_r4();
    t_change_r6();
    t_bypass_r3();
    t_disable_r7();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule